// File: doc/BRIEF.md
# Dual Decade Divider

The block contains two matching decade counters. Every decade is built from two stages, each with its own count input. A one-bit toggle stage drives Q0. A three-bit modulo-5 stage drives Q3..Q1. Each stage advances on the falling edge of its count input. A per-decade mode input links the two stages in one of three ways. The stages can stay independent. In BCD counting, Q0 carries into the modulo-5 stage. In bi-quinary counting, Q3 carries into the toggle stage, and Q0 becomes a square divide-by-10 output. A chain enable forwards the first decade's top output to the second decade, which gives divide-by-100.

Everything runs on one system clock. The count inputs are asynchronous. Each one passes through a synchronizer and a falling-edge detector, so the ripple structure becomes single-cycle count enables. A carry between stages, and between decades, is applied in the same system cycle as the event that causes it. Each decade has its own active-high clear. Each decade also gives a one-cycle wrap pulse when its top output falls.

Top module: `dual_decade_div`

## Requirements
- R1: A falling edge on a count input advances its stage exactly once. The output changes on the third rising clock edge after the input changes between edges. A rising edge changes nothing.
- R2: With mode 2'b00 (independent), the modulo-5 stage steps Q3..Q1 through 0,1,2,3,4 and back to 0 on each falling edge of the second count input, and Q0 toggles on each falling edge of the first count input.
- R3: With mode 2'b01 (BCD), falling edges on the first count input make Q3..Q0 count binary 0 to 9 and wrap to 0, and the second count input has no effect.
- R4: With mode 2'b10 (bi-quinary), falling edges on the second count input cycle Q3..Q1 through 0 to 4, Q0 toggles each time Q3 falls, and the first count input has no effect.
- R5: While a decade's clear input is high, its four outputs read 0 in the same cycle, its count events are dropped, and the other decade is not affected. After release it counts from 0.
- R6: A decade's wrap pulse is high for exactly one cycle each time its top output falls. The top output is Q3 in BCD and independent modes and Q0 in bi-quinary mode. The pulse appears in the same cycle as the outputs that show the wrap.
- R7: With the chain enable high, each fall of decade 1's top output advances decade 2 as its external count. This replaces decade 2's own external count pin, which is the first pin in BCD and independent modes and the second pin in bi-quinary mode. With both decades in BCD this divides by 100.
- R8: Mode code 2'b11 behaves as independent.
- R9: A low on rst_n at a rising clock edge sets all outputs and wrap pulses to 0.
- R10: Output bit 4d holds Q0 of decade d, and bits 4d+3..4d+1 hold Q3..Q1 of decade d. Decade d's mode is dec_mode[2d+1:2d].

Note on encoding: output bit 4d is Q0 and bits 4d+3..4d+1 are Q3..Q1 of decade d, as stated in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_lo_in | input | 2 | Count input of each decade's toggle stage (first pin) |
| cnt_hi_in | input | 2 | Count input of each decade's modulo-5 stage (second pin) |
| clr_in | input | 2 | Active-high clear, one per decade |
| dec_mode | input | 4 | Linking mode, two bits per decade |
| chain_en | input | 1 | Forward decade 1's top output to decade 2 |
| cnt_q | output | 8 | Q3..Q0 of both decades |
| wrap_pulse | output | 2 | One-cycle wrap pulse per decade |

## Verification
The bench checks the exact sampling latency. A design with one synchronizer flop too many or too few moves the output a cycle off, and one that fires on a rising edge changes the count too early. The wrap points get directed attention: 9 to 0 in BCD, the fall of Q0 in bi-quinary, and the 100th count in the chained setup. A carry applied a cycle late, or a wrap pulse that lasts two cycles, shows up as a wrong digit or a wrong pulse count. The bench also drives the pin that a mode should ignore, and pulses a decade while it is cleared. A wrong input route or a leaky clear then changes the count.

// File: rtl/decdiv_pkg.sv
// Package: shared mode encoding and stage sizes for the dual decade divider.
// Assumes: the mode codes are fixed by the block's requirements.
package decdiv_pkg;

    // Linking mode of one decade.
    typedef enum logic [1:0] {
        MODE_SPLIT = 2'b00,
        MODE_BCD   = 2'b01,
        MODE_BIQ   = 2'b10,
        MODE_RSVD  = 2'b11
    } dmode_e;

    localparam int HI_MODULUS = 5;
    localparam int HI_WIDTH   = $clog2(HI_MODULUS);
    localparam int DIGIT_W    = HI_WIDTH + 1;

endpackage

// File: rtl/decdiv_fall_sync.sv
// Module: brings one asynchronous count pin into the clock domain and flags
// its falling edges as a one-cycle pulse.
// Assumes: the pin stays in each level for longer than one clock period.
module decdiv_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic fall_out
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain followed by a one-cycle delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    // High for one cycle after the synchronized level drops.
    assign fall_out = last_q & ~sync_q[STAGES-1];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_out |=> !fall_out); // R1

endmodule

// File: rtl/decdiv_toggle_stage.sv
// Module: the divide-by-2 stage of a decade; its bit flips on each advance.
// Assumes: adv_in is already gated by the decade clear.
module decdiv_toggle_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv_in,
    output logic bit_q
);

    // Toggle on advance, zero on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (clr)    bit_q <= 1'b0;
        else if (adv_in) bit_q <= ~bit_q;
    end

    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_in && !clr) |=> $stable(bit_q)); // R1

endmodule

// File: rtl/decdiv_mod_stage.sv
// Module: the modulo-N stage of a decade (N = 5 by default). It counts up
// and returns to zero from the last state or from any unused state.
// Assumes: adv_in is already gated by the decade clear.
module decdiv_mod_stage #(
    parameter int MODULUS = 5,
    localparam int W = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv_in,
    output logic [W-1:0] state_q
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    logic [W-1:0] next_state;

    // Next count value; unused codes fold back to zero.
    always_comb begin
        if (state_q >= LAST) next_state = '0;
        else                 next_state = state_q + 1'b1;
    end

    // State register with clear priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= '0;
        else if (clr)    state_q <= '0;
        else if (adv_in) state_q <= next_state;
    end

    AST_MOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_in && !clr && state_q >= LAST) |=> state_q == '0); // R2
    AST_MOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_in && !clr && state_q < LAST) |=> state_q == $past(state_q) + 1'b1); // R2
    AST_MOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q <= LAST); // R2

endmodule

// File: rtl/decdiv_decade.sv
// Module: one decade. It routes its count events to the two stages by
// mode, makes the top-output fall event and registers the wrap pulse.
// Assumes: carries are applied in the same cycle as the causing event.
module decdiv_decade
    import decdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [1:0]         mode,
    input  logic               fall_lo,
    input  logic               fall_hi,
    input  logic               chain_evt,
    input  logic               chain_sel,
    output logic [DIGIT_W-1:0] digit,
    output logic               top_fall,
    output logic               wrap
);

    logic                is_bcd;
    logic                is_biq;
    logic                ext_in;
    logic                adv_lo;
    logic                adv_hi;
    logic                lo_q;
    logic [HI_WIDTH-1:0] hi_q;
    logic                wrap_q;

    // Mode decode; the reserved code falls through to independent stages.
    assign is_bcd = (mode == MODE_BCD);
    assign is_biq = (mode == MODE_BIQ);

    // External count source: the chain event or this decade's own pin.
    assign ext_in = chain_sel ? chain_evt : (is_biq ? fall_hi : fall_lo);

    // Toggle stage advance: a carry from Q3 in bi-quinary, else external.
    assign adv_lo = ~clr & (is_biq ? (ext_in & hi_q[HI_WIDTH-1]) : ext_in);

    // Modulo stage advance: a carry from Q0 in BCD, external in
    // bi-quinary, the second pin otherwise.
    assign adv_hi = ~clr & (is_bcd ? (ext_in & lo_q) : (is_biq ? ext_in : fall_hi));

    // Top output fall: Q0 in bi-quinary, Q3 in the other modes.
    assign top_fall = is_biq ? (adv_lo & lo_q) : (adv_hi & hi_q[HI_WIDTH-1]);

    decdiv_toggle_stage u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .adv_in (adv_lo),
        .bit_q  (lo_q)
    );

    decdiv_mod_stage #(.MODULUS(HI_MODULUS)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .adv_in  (adv_hi),
        .state_q (hi_q)
    );

    // Wrap pulse register, aligned with the outputs that show the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)   wrap_q <= 1'b0;
        else if (clr) wrap_q <= 1'b0;
        else          wrap_q <= top_fall;
    end

    // Clear forces the visible outputs low at once.
    assign digit = clr ? '0 : {hi_q, lo_q};
    assign wrap  = wrap_q & ~clr;

    AST_BCD_NINE_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bcd && !clr && ext_in && lo_q && hi_q == 3'd4) |=> (hi_q == 3'd0 && !lo_q && wrap_q)); // R3
    AST_BIQ_Q0_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_biq && !clr && ext_in && hi_q == 3'd4) |=> lo_q != $past(lo_q)); // R4
    AST_BIQ_Q0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_biq && !clr && hi_q != 3'd4) |=> lo_q == $past(lo_q)); // R4
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (hi_q == '0 && !lo_q && !wrap_q)); // R5
    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |=> !wrap_q); // R6

endmodule

// File: rtl/dual_decade_div.sv
// Module: the top level. It holds one pair of pin synchronizers per decade
// and the decades themselves, and forwards each decade's top-output fall
// to the next decade when the chain enable is set.
// Assumes: NUM_DECADES >= 2; the chain enables are changed only while
// no count is in flight.
module dual_decade_div
    import decdiv_pkg::*;
#(
    parameter int NUM_DECADES = 2,
    parameter int SYNC_STAGES = 2,
    localparam int QW = DIGIT_W * NUM_DECADES,
    localparam int MW = 2 * NUM_DECADES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_DECADES-1:0] cnt_lo_in,
    input  logic [NUM_DECADES-1:0] cnt_hi_in,
    input  logic [NUM_DECADES-1:0] clr_in,
    input  logic [MW-1:0]          dec_mode,
    input  logic [NUM_DECADES-2:0] chain_en,
    output logic [QW-1:0]          cnt_q,
    output logic [NUM_DECADES-1:0] wrap_pulse
);

    logic [NUM_DECADES-1:0] fall_lo;
    logic [NUM_DECADES-1:0] fall_hi;
    logic [NUM_DECADES-1:0] top_fall;
    logic [NUM_DECADES-1:0] chain_evt;
    logic [NUM_DECADES-1:0] chain_sel;

    for (genvar d = 0; d < NUM_DECADES; d++) begin : g_dec
        decdiv_fall_sync #(.STAGES(SYNC_STAGES)) u_sync_lo (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_in   (cnt_lo_in[d]),
            .fall_out (fall_lo[d])
        );

        decdiv_fall_sync #(.STAGES(SYNC_STAGES)) u_sync_hi (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_in   (cnt_hi_in[d]),
            .fall_out (fall_hi[d])
        );

        // The first decade has no upstream; later ones may take the chain.
        if (d == 0) begin : g_head
            assign chain_evt[d] = 1'b0;
            assign chain_sel[d] = 1'b0;
        end else begin : g_link
            assign chain_evt[d] = top_fall[d-1];
            assign chain_sel[d] = chain_en[d-1];
        end

        decdiv_decade u_decade (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr_in[d]),
            .mode      (dec_mode[2*d +: 2]),
            .fall_lo   (fall_lo[d]),
            .fall_hi   (fall_hi[d]),
            .chain_evt (chain_evt[d]),
            .chain_sel (chain_sel[d]),
            .digit     (cnt_q[DIGIT_W*d +: DIGIT_W]),
            .top_fall  (top_fall[d]),
            .wrap      (wrap_pulse[d])
        );

        AST_WRAP_FOLLOWS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            top_fall[d] |=> (wrap_pulse[d] || clr_in[d])); // R6
    end

endmodule

// File: tb/dual_decade_div_tb_top.sv
// Bench: directed corner cases plus seeded random pin pulses. A
// transaction-level model in bench functions gives the expected values.
module dual_decade_div_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lo_pin = '0;
    logic [1:0] hi_pin = '0;
    logic [1:0] clr = '0;
    logic [3:0] mode = '0;
    logic [0:0] chain = '0;
    logic [7:0] q;
    logic [1:0] wp;

    int n_checks = 0;
    int n_fail = 0;
    int m_a[2];
    int m_b[2];
    int tc_exp[2];
    int tc_seen[2];
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_decade_div dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_lo_in  (lo_pin),
        .cnt_hi_in  (hi_pin),
        .clr_in     (clr),
        .dec_mode   (mode),
        .chain_en   (chain),
        .cnt_q      (q),
        .wrap_pulse (wp)
    );

    // Watchdog and wrap-pulse counter.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) for (int d = 0; d < 2; d++) if (wp[d]) tc_seen[d]++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
            $finish;
        end
    end

    function automatic int eff_mode(int d);
        int md = int'(mode[2*d +: 2]);
        return (md == 3) ? 0 : md;
    endfunction

    function automatic bit adv_a(int d);
        if (m_a[d] == 1) begin m_a[d] = 0; return 1'b1; end
        m_a[d] = 1;
        return 1'b0;
    endfunction

    function automatic bit adv_b(int d);
        if (m_b[d] >= 4) begin m_b[d] = 0; return 1'b1; end
        m_b[d] = m_b[d] + 1;
        return 1'b0;
    endfunction

    // One external count into decade d; returns 1 when its top output falls.
    function automatic bit ext_evt(int d);
        bit top = 1'b0;
        case (eff_mode(d))
            1: if (adv_a(d)) top = adv_b(d);
            2: if (adv_b(d)) top = adv_a(d);
            default: void'(adv_a(d));
        endcase
        return top;
    endfunction

    function automatic void top_event(int d);
        tc_exp[d]++;
        if (d == 0 && chain[0] && !clr[1]) begin
            if (ext_evt(1)) tc_exp[1]++;
        end
    endfunction

    // Model of one falling edge on pin p (0 first, 1 second) of decade d.
    function automatic void pin_event(int d, int p);
        int md = eff_mode(d);
        int path = (md == 2) ? 1 : 0;
        if (clr[d]) return;
        if (d == 1 && chain[0] && p == path) return;
        if (md == 0) begin
            if (p == 0) void'(adv_a(d));
            else if (adv_b(d)) top_event(d);
        end else if (p == path) begin
            if (ext_evt(d)) top_event(d);
        end
    endfunction

    function automatic logic [7:0] exp_word();
        logic [7:0] w;
        for (int d = 0; d < 2; d++) begin
            w[4*d]       = clr[d] ? 1'b0 : m_a[d][0];
            w[4*d+1 +: 3] = clr[d] ? 3'd0 : m_b[d][2:0];
        end
        return w;
    endfunction

    task automatic check_q(string req);
        n_checks++;
        if (q !== exp_word()) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, q, exp_word());
        end
    endtask

    task automatic check_val(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Full pulse on one pin: rise, check nothing moved (R1), fall, settle.
    task automatic pulse(int d, int p, string req);
        @(negedge clk);
        if (p == 0) lo_pin[d] = 1'b1; else hi_pin[d] = 1'b1;
        repeat (3) @(negedge clk);
        check_q("R1 rising edge ignored");
        if (p == 0) lo_pin[d] = 1'b0; else hi_pin[d] = 1'b0;
        pin_event(d, p);
        repeat (4) @(negedge clk);
        check_q(req);
    endtask

    task automatic model_zero();
        for (int d = 0; d < 2; d++) begin m_a[d] = 0; m_b[d] = 0; end
    endtask

    initial begin
        void'($urandom(32'd2718));
        model_zero();
        for (int d = 0; d < 2; d++) begin tc_exp[d] = 0; tc_seen[d] = 0; end
        repeat (4) @(negedge clk);
        check_q("R9 reset outputs");
        check_val("R9 reset wrap", int'(wp), 0);
        rst_n = 1'b1;

        // R1: exact latency on decade 0, first pin, independent mode.
        @(negedge clk);
        lo_pin[0] = 1'b1;
        repeat (3) @(negedge clk);
        lo_pin[0] = 1'b0;
        repeat (2) @(negedge clk);
        check_q("R1 not yet at second edge");
        pin_event(0, 0);
        @(negedge clk);
        check_q("R1 change at third edge");

        // R2: independent stages, modulo-5 sequence on decade 1.
        for (int i = 0; i < 6; i++) pulse(1, 1, "R2 modulo-5 step");
        pulse(1, 0, "R2 toggle stage");

        // R3: BCD on decade 0 through the wrap, second pin ignored.
        mode = 4'b0001;
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        model_zero();
        for (int d = 0; d < 2; d++) begin tc_exp[d] = 0; tc_seen[d] = 0; end
        for (int i = 0; i < 9; i++) pulse(0, 0, "R3 BCD count");
        check_val("R3 nine", int'(q[3:0]), 9);
        pulse(0, 1, "R3 second pin ignored");
        pulse(0, 0, "R3 BCD wrap to zero");
        check_val("R6 BCD wrap pulse", tc_seen[0], 1);

        // R4: bi-quinary on decade 1, first pin ignored.
        mode = 4'b1001;
        for (int i = 0; i < 10; i++) pulse(1, 1, "R4 bi-quinary count");
        pulse(1, 0, "R4 first pin ignored");
        check_val("R6 bi-quinary wrap pulses", tc_seen[1], tc_exp[1]);

        // R8: reserved code acts as independent.
        mode = 4'b1100;
        pulse(1, 0, "R8 reserved toggle");
        pulse(1, 1, "R8 reserved modulo step");

        // R7: chained BCD, divide by 100.
        mode = 4'b0101;
        chain = 1'b1;
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        model_zero();
        for (int d = 0; d < 2; d++) begin tc_exp[d] = 0; tc_seen[d] = 0; end
        for (int i = 0; i < 10; i++) pulse(0, 0, "R7 chain");
        check_val("R7 decade 2 after ten", int'(q[7:4]), 1);
        pulse(1, 0, "R7 own pin replaced by chain");
        for (int i = 0; i < 90; i++) pulse(0, 0, "R7 chain");
        check_val("R7 divide by 100 wraps", tc_seen[1], 1);
        check_val("R6 decade 1 wraps", tc_seen[0], 10);

        // R5: clear decade 1 mid-count; decade 0 keeps its value.
        for (int i = 0; i < 3; i++) pulse(0, 0, "R5 setup");
        mode = 4'b0001;
        chain = 1'b0;
        for (int i = 0; i < 4; i++) pulse(1, 1, "R5 setup");
        @(negedge clk);
        clr[1] = 1'b1;
        #1;
        m_a[1] = 0; m_b[1] = 0;
        check_q("R5 clear immediate");
        pulse(1, 1, "R5 count dropped while clear");
        pulse(1, 0, "R5 count dropped while clear");
        @(negedge clk);
        clr[1] = 1'b0;
        #1;
        check_q("R5 after release");
        pulse(1, 1, "R5 counts from zero");

        // Random phase.
        for (int i = 0; i < 1200; i++) begin
            int r = int'($urandom_range(0, 59));
            if (r == 0) begin
                mode = 4'($urandom_range(0, 15));
                chain = 1'($urandom_range(0, 1));
            end else if (r == 1) begin
                int d = int'($urandom_range(0, 1));
                @(negedge clk);
                clr[d] = 1'b1;
                m_a[d] = 0; m_b[d] = 0;
                @(negedge clk);
                clr[d] = 1'b0;
                #1;
                check_q("R5 random clear");
            end else begin
                pulse(int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                      "R10 random count");
            end
        end
        repeat (2) @(negedge clk);
        check_val("R6 wrap count decade 1", tc_seen[0], tc_exp[0]);
        check_val("R6 wrap count decade 2", tc_seen[1], tc_exp[1]);

        // R9: reset in the middle of counting.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        model_zero();
        check_q("R9 reset mid-run");
        check_val("R9 wrap cleared", int'(wp), 0);
        rst_n = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule